// File: doc/BRIEF.md
# Raster Sync Timing Analyzer

This block watches a raw raster video stream (horizontal sync, vertical sync and a data-enable flag marking active pixels), one pixel per clock, and reports its timing: totals, active size, sync width, back porch, front porch and sync polarity for both the horizontal axis (in pixel clocks) and the vertical axis (in lines). A consumer waits for the one-cycle `done_o` strobe and then reads a complete, self-consistent set of results. `valid_o` tells it whether they are usable.

Every measurement counter restarts at the rising edge of its own sync signal, whatever the polarity. So a sync that is active low looks, to the counters, like a pulse that spans back porch, active region and front porch. Polarity is therefore inferred: a sync count larger than the active size means negative polarity. One of two sets of formulas then turns the raw positions into porch and sync widths.

The control path is a three-state machine. `ST_WAIT` idles until a vertical sync rising edge arrives (transition *arm*) and moves to `ST_RUN`. In `ST_RUN` the next vertical rising edge closes a frame (transition *close*) into `ST_PUBLISH`. If too many lines pass with no vertical edge (transition *lost*), it drops back to `ST_WAIT` and clears `valid_o`. `ST_PUBLISH` latches the results, raises `done_o` and always returns to `ST_RUN` (transition *resume*).

Top module: `vtm_top`

## Requirements
- R1: The horizontal position is 0 on the clock in which hsync_in is first seen high after being low, and rises by one every clock. The vertical position is 0 on the clock in which vsync_in is first seen high after being low, and rises by one on each horizontal rising edge.
- R2: h_total_o is the number of clocks between consecutive hsync rising edges. v_total_o is the number of hsync rising edges from one vsync rising edge up to and including the next.
- R3: An axis is reported with positive polarity (pos_pol output 1) when its sync count, taken as the position at the sync falling edge, is not larger than its active size. It is reported negative (0) when the count is larger. Equal values give positive.
- R4: For positive polarity: sync width = sync count, back porch = first active position − sync count, front porch = total − last active position.
- R5: For negative polarity: back porch = first active position, front porch = sync count − last active position, sync width = total − sync count.
- R6: Active size = last active position − first active position + 1. Positions are those of the clocks (horizontal) or lines (vertical) where de_in is high. Horizontal edges come from the most recent line that had any active pixel.
- R7: done_o is high for exactly one clock, two clocks after the clock in which a vsync rising edge is sampled. There is no strobe for the first vsync rising edge after reset or after a loss of sync.
- R8: All result outputs stay unchanged except in the clock where done_o is high.
- R9: valid_o is 1 after a strobe only when the frame had at least one active pixel, both syncs fell within their periods, and first ≤ last on both axes. A frame without any active pixel gives valid_o = 0.
- R10: If TMO_LINES hsync rising edges pass with no vsync rising edge, valid_o is cleared on the following clock. The next vsync rising edge re-arms without a strobe.
- R11: After reset, done_o, valid_o and every result output are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hsync_in | input | 1 | Raw horizontal sync |
| vsync_in | input | 1 | Raw vertical sync |
| de_in | input | 1 | Active-pixel flag |
| done_o | output | 1 | One-clock result strobe |
| valid_o | output | 1 | Results are consistent |
| h_total_o | output | 12 | Clocks per line |
| h_active_o | output | 12 | Active pixels per line |
| h_sync_w_o | output | 12 | Horizontal sync width |
| h_bp_o | output | 12 | Horizontal back porch |
| h_fp_o | output | 12 | Horizontal front porch |
| h_pos_pol_o | output | 1 | 1 = positive hsync |
| v_total_o | output | 12 | Lines per frame |
| v_active_o | output | 12 | Active lines per frame |
| v_sync_w_o | output | 12 | Vertical sync width |
| v_bp_o | output | 12 | Vertical back porch |
| v_fp_o | output | 12 | Vertical front porch |
| v_pos_pol_o | output | 1 | 1 = positive vsync |

## Verification
The bench drives inputs on the falling clock edge and counts falling edges from the one where a vertical rising edge was driven. The rising edge after it moves the machine to ST_PUBLISH and the next one latches the results, so `done_o` and all result fields are sampled at the second falling edge and `done_o` is checked low at the third. Hold behaviour is checked at the sixth falling edge by comparing against the values captured at the strobe. A loss of sync clears `valid_o` one clock after the limiting line, so the bench checks it only after several further lines have passed. Expected fields come from the generated widths through the porch and polarity rules, across a sweep of both polarities, several sizes and the equal-count boundary.

// File: rtl/vtm_pkg.sv
package vtm_pkg;
    localparam int CNT_W = 12;
    typedef logic [CNT_W-1:0] cnt_t;

    // Raw per-period capture of one axis, positions taken from sync rise
    typedef struct packed {
        cnt_t total;
        cnt_t sync_cnt;
        cnt_t first;
        cnt_t last;
        logic seen;
        logic fell;
    } axis_snap_t;

    // Derived timing of one axis
    typedef struct packed {
        cnt_t total;
        cnt_t active;
        cnt_t sync_w;
        cnt_t bp;
        cnt_t fp;
        logic pos_pol;
        logic ok;
    } axis_res_t;

    typedef enum logic [1:0] {
        ST_WAIT    = 2'd0,
        ST_RUN     = 2'd1,
        ST_PUBLISH = 2'd2
    } mstate_t;
endpackage

// File: rtl/vtm_sync_edge.sv
module vtm_sync_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_in,
    output logic rise_o,
    output logic fall_o
);
    logic prev_q;

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= sync_in;
    end

    assign rise_o = sync_in & ~prev_q;
    assign fall_o = ~sync_in & prev_q;
endmodule

// File: rtl/vtm_axis_meas.sv
module vtm_axis_meas
    import vtm_pkg::*;
#(
    parameter bit HOLD_EDGES = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       step,
    input  logic       restart,
    input  logic       fall,
    input  logic       act,
    output axis_snap_t snap_o
);
    cnt_t pos_q;
    cnt_t cur;
    cnt_t first_q;
    cnt_t last_q;
    cnt_t sync_q;
    logic seen_q;
    logic fell_q;

    // Position of the current clock, counted from the sync rising edge
    always_comb begin
        if (restart)   cur = '0;
        else if (step) cur = pos_q + cnt_t'(1);
        else           cur = pos_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pos_q   <= '0;
            first_q <= '0;
            last_q  <= '0;
            sync_q  <= '0;
            seen_q  <= 1'b0;
            fell_q  <= 1'b0;
            snap_o  <= '0;
        end else begin
            pos_q <= cur;
            if (restart) begin
                snap_o.total    <= pos_q + cnt_t'(1);
                snap_o.sync_cnt <= sync_q;
                snap_o.fell     <= fell_q;
                if (!HOLD_EDGES || seen_q) begin
                    snap_o.first <= first_q;
                    snap_o.last  <= last_q;
                end
                snap_o.seen <= HOLD_EDGES ? (snap_o.seen | seen_q) : seen_q;
                seen_q  <= act;
                first_q <= '0;
                last_q  <= '0;
                fell_q  <= 1'b0;
            end else begin
                if (act) begin
                    if (!seen_q) first_q <= cur;
                    last_q <= cur;
                    seen_q <= 1'b1;
                end
                if (fall) begin
                    sync_q <= cur;
                    fell_q <= 1'b1;
                end
            end
        end
    end

    AST_EDGE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && seen_q) |=> (snap_o.first <= snap_o.last)); // R6
endmodule

// File: rtl/vtm_axis_calc.sv
module vtm_axis_calc
    import vtm_pkg::*;
(
    input  axis_snap_t snap_i,
    output axis_res_t  res_o
);
    cnt_t active;
    logic neg;

    always_comb begin
        active = snap_i.last - snap_i.first + cnt_t'(1);
        neg    = snap_i.sync_cnt > active;
        res_o.total   = snap_i.total;
        res_o.active  = active;
        res_o.pos_pol = ~neg;
        res_o.ok      = snap_i.seen & snap_i.fell & (snap_i.first <= snap_i.last);
        if (neg) begin
            res_o.sync_w = snap_i.total - snap_i.sync_cnt;
            res_o.bp     = snap_i.first;
            res_o.fp     = snap_i.sync_cnt - snap_i.last;
        end else begin
            res_o.sync_w = snap_i.sync_cnt;
            res_o.bp     = snap_i.first - snap_i.sync_cnt;
            res_o.fp     = snap_i.total - snap_i.last;
        end
    end
endmodule

// File: rtl/vtm_top.sv
module vtm_top
    import vtm_pkg::*;
#(
    parameter int TMO_LINES = 4096
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hsync_in,
    input  logic             vsync_in,
    input  logic             de_in,
    output logic             done_o,
    output logic             valid_o,
    output logic [CNT_W-1:0] h_total_o,
    output logic [CNT_W-1:0] h_active_o,
    output logic [CNT_W-1:0] h_sync_w_o,
    output logic [CNT_W-1:0] h_bp_o,
    output logic [CNT_W-1:0] h_fp_o,
    output logic             h_pos_pol_o,
    output logic [CNT_W-1:0] v_total_o,
    output logic [CNT_W-1:0] v_active_o,
    output logic [CNT_W-1:0] v_sync_w_o,
    output logic [CNT_W-1:0] v_bp_o,
    output logic [CNT_W-1:0] v_fp_o,
    output logic             v_pos_pol_o
);
    localparam int AXES = 2;          // 0 = horizontal, 1 = vertical
    localparam int TW   = $clog2(TMO_LINES + 1);

    logic [AXES-1:0] sync_raw;
    logic [AXES-1:0] rise;
    logic [AXES-1:0] fall;
    logic [AXES-1:0] step;
    axis_snap_t      snap [AXES];
    axis_res_t       res  [AXES];

    assign sync_raw = {vsync_in, hsync_in};
    assign step     = {rise[0], 1'b1};

    for (genvar g = 0; g < AXES; g++) begin : g_axis
        vtm_sync_edge u_edge (
            .clk    (clk),
            .rst_n  (rst_n),
            .sync_in(sync_raw[g]),
            .rise_o (rise[g]),
            .fall_o (fall[g])
        );
        vtm_axis_meas #(.HOLD_EDGES(g == 0)) u_meas (
            .clk    (clk),
            .rst_n  (rst_n),
            .step   (step[g]),
            .restart(rise[g]),
            .fall   (fall[g]),
            .act    (de_in),
            .snap_o (snap[g])
        );
        vtm_axis_calc u_calc (
            .snap_i(snap[g]),
            .res_o (res[g])
        );
    end

    // Lines seen since the last vertical rising edge, saturating at the limit
    logic [TW-1:0] lines_q;
    logic          tmo_hit;
    assign tmo_hit = (lines_q == TW'(TMO_LINES));

    always_ff @(posedge clk) begin
        if (!rst_n)                 lines_q <= '0;
        else if (rise[1])           lines_q <= '0;
        else if (rise[0] && !tmo_hit) lines_q <= lines_q + TW'(1);
    end

    mstate_t state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT:    if (rise[1]) state_d = ST_RUN;              // arm
            ST_RUN: begin
                if (rise[1])      state_d = ST_PUBLISH;              // close
                else if (tmo_hit) state_d = ST_WAIT;                 // lost
            end
            ST_PUBLISH: state_d = ST_RUN;                            // resume
            default:    state_d = ST_WAIT;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_o      <= 1'b0;
            valid_o     <= 1'b0;
            h_total_o   <= '0;
            h_active_o  <= '0;
            h_sync_w_o  <= '0;
            h_bp_o      <= '0;
            h_fp_o      <= '0;
            h_pos_pol_o <= 1'b0;
            v_total_o   <= '0;
            v_active_o  <= '0;
            v_sync_w_o  <= '0;
            v_bp_o      <= '0;
            v_fp_o      <= '0;
            v_pos_pol_o <= 1'b0;
        end else begin
            done_o <= (state_q == ST_PUBLISH);
            if (state_q == ST_PUBLISH) begin
                valid_o     <= res[0].ok & res[1].ok;
                h_total_o   <= res[0].total;
                h_active_o  <= res[0].active;
                h_sync_w_o  <= res[0].sync_w;
                h_bp_o      <= res[0].bp;
                h_fp_o      <= res[0].fp;
                h_pos_pol_o <= res[0].pos_pol;
                v_total_o   <= res[1].total;
                v_active_o  <= res[1].active;
                v_sync_w_o  <= res[1].sync_w;
                v_bp_o      <= res[1].bp;
                v_fp_o      <= res[1].fp;
                v_pos_pol_o <= res[1].pos_pol;
            end else if (state_q == ST_RUN && tmo_hit && !rise[1]) begin
                valid_o <= 1'b0;
            end
        end
    end

    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o); // R7
    AST_HOLD_RESULTS: assert property (@(posedge clk) disable iff (!rst_n)
        !done_o |-> ($stable(h_total_o) && $stable(v_total_o) && $stable(h_bp_o) && $stable(v_fp_o))); // R8
    AST_LINE_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && valid_o) |-> (cnt_t'(h_sync_w_o + h_bp_o + h_active_o + h_fp_o) == cnt_t'(h_total_o + cnt_t'(1)))); // R4
    AST_FRAME_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && valid_o) |-> (cnt_t'(v_sync_w_o + v_bp_o + v_active_o + v_fp_o) == cnt_t'(v_total_o + cnt_t'(1)))); // R5
    AST_TMO_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_RUN && tmo_hit && !rise[1]) |=> !valid_o); // R10
endmodule

// File: tb/sim_vtm_top.sv
module sim_vtm_top;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic hs = 1'b0, vs = 1'b0, de = 1'b0;
    logic done, valid, hpp, vpp;
    logic [11:0] ht, ha, hsw, hbp, hfp, vt, va, vsw, vbp, vfp;

    int n_chk = 0, n_err = 0;
    int since_vr = 100000;
    bit running = 0, exp_done = 0, have_cap = 0;
    int e_ht, e_ha, e_hs, e_hb, e_hf, e_hp, e_vt, e_va, e_vs, e_vb, e_vf, e_vp, e_valid;
    int cap_ht, cap_vt;

    always #10 clk = ~clk;

    vtm_top #(.TMO_LINES(64)) u0 (
        .clk(clk), .rst_n(rst_n), .hsync_in(hs), .vsync_in(vs), .de_in(de),
        .done_o(done), .valid_o(valid),
        .h_total_o(ht), .h_active_o(ha), .h_sync_w_o(hsw), .h_bp_o(hbp), .h_fp_o(hfp), .h_pos_pol_o(hpp),
        .v_total_o(vt), .v_active_o(va), .v_sync_w_o(vsw), .v_bp_o(vbp), .v_fp_o(vfp), .v_pos_pol_o(vpp)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic bit lvl(int pos, int w, int bp, int a, int fp, bit pp);
        return pp ? (pos < w) : (pos < bp + a + fp);
    endfunction

    function automatic bit act_at(int pos, int w, int bp, int a, bit pp);
        int s = pp ? w + bp : bp;
        return (pos >= s) && (pos < s + a);
    endfunction

    // Called at each falling edge before new inputs are driven
    task automatic tick();
        if (since_vr < 100000) since_vr++;
        if (since_vr == 2) begin
            chk("R7 done strobe", done, exp_done);
            if (exp_done && done) begin
                chk("R9 valid", valid, e_valid);
                if (e_valid == 1) begin
                    chk("R2 h_total", ht, e_ht);
                    chk("R6 h_active", ha, e_ha);
                    chk("R4/R5 h_sync_w", hsw, e_hs);
                    chk("R4/R5 h_bp", hbp, e_hb);
                    chk("R4/R5 h_fp", hfp, e_hf);
                    chk("R3 h_pos_pol", hpp, e_hp);
                    chk("R2 v_total", vt, e_vt);
                    chk("R6 v_active", va, e_va);
                    chk("R4/R5 v_sync_w", vsw, e_vs);
                    chk("R4/R5 v_bp", vbp, e_vb);
                    chk("R4/R5 v_fp", vfp, e_vf);
                    chk("R3 v_pos_pol", vpp, e_vp);
                end
                cap_ht = ht; cap_vt = vt; have_cap = 1;
            end
        end else if (since_vr == 3) begin
            chk("R7 done one clock", done, 0);
        end else if (since_vr == 6 && have_cap) begin
            chk("R8 h_total held", ht, cap_ht);
            chk("R8 v_total held", vt, cap_vt);
        end
    endtask

    task automatic run_frame(input int hw, hb, hac, hf, input bit hp,
                             input int vw, vb, vac, vf, input bit vp, input bit nodata);
        int htot = hw + hb + hac + hf;
        int vtot = vw + vb + vac + vf;
        int hcnt = hp ? hw : hb + hac + hf;   // R1: positions from the rising edge
        int vcnt = vp ? vw : vb + vac + vf;
        for (int l = 0; l < vtot; l++) begin
            for (int p = 0; p < htot; p++) begin
                @(negedge clk);
                tick();
                if (l == 0 && p == 0) begin
                    exp_done = running;
                    running  = 1;
                    since_vr = 0;
                end
                hs = lvl(p, hw, hb, hac, hf, hp);
                vs = lvl(l, vw, vb, vac, vf, vp);
                de = !nodata && act_at(p, hw, hb, hac, hp) && act_at(l, vw, vb, vac, vp);
            end
        end
        e_ht = htot; e_ha = hac; e_hs = hw; e_hb = hb; e_hf = hf + 1;
        e_hp = (hcnt > hac) ? 0 : 1;
        e_vt = vtot; e_va = vac; e_vs = vw; e_vb = vb; e_vf = vf + 1;
        e_vp = (vcnt > vac) ? 0 : 1;
        e_valid = nodata ? 0 : 1;
    endtask

    task automatic idle_lines(input int n, input int hw, hb, hac, hf, input bit hp);
        for (int l = 0; l < n; l++)
            for (int p = 0; p < hw + hb + hac + hf; p++) begin
                @(negedge clk);
                tick();
                hs = lvl(p, hw, hb, hac, hf, hp);
                vs = 1'b0;
                de = 1'b0;
            end
        running = 0;
    endtask

    initial begin
        #(200000 * 20);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk("R11 done reset", done, 0);
        chk("R11 valid reset", valid, 0);
        chk("R11 h_total reset", ht, 0);
        chk("R11 v_fp reset", vfp, 0);
        rst_n = 1'b1;
        // Sweep of polarities and sizes; hw==hac hits the equal-count boundary (R3)
        for (int hp = 0; hp < 2; hp++)
            for (int vp = 0; vp < 2; vp++)
                for (int hw = 2; hw <= 3; hw++)
                    for (int hac = 3; hac <= 5; hac += 2)
                        run_frame(hw, 1 + hw % 2, hac, 1 + hp, bit'(hp),
                                  1 + vp, 1 + (hac % 3), 2 + hp, 1 + (hw % 2), bit'(vp), 1'b0);
        // Frame without active pixels (R9), then a normal one
        run_frame(2, 2, 4, 1, 1'b1, 1, 2, 3, 1, 1'b0, 1'b1);
        run_frame(2, 2, 4, 1, 1'b1, 1, 2, 3, 1, 1'b0, 1'b0);
        run_frame(2, 2, 4, 1, 1'b1, 1, 2, 3, 1, 1'b0, 1'b0);
        @(negedge clk); tick();
        chk("R9 valid before loss", valid, 1);
        // Loss of vertical sync (R10)
        idle_lines(70, 2, 2, 4, 1, 1'b1);
        chk("R10 valid cleared on loss", valid, 0);
        run_frame(3, 1, 5, 2, 1'b0, 2, 1, 3, 2, 1'b1, 1'b0);
        run_frame(3, 1, 5, 2, 1'b0, 2, 1, 3, 2, 1'b1, 1'b0);
        run_frame(3, 1, 5, 2, 1'b0, 2, 1, 3, 2, 1'b1, 1'b0);
        repeat (4) begin @(negedge clk); tick(); end
        $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end
endmodule